// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block arbitrates among a parameterised set of external interrupt request lines. Each line carries an enable flag, a pending flag, an active flag and a 4-bit urgency value, where a smaller number means a more urgent request. A single 3-bit grouping setting decides, at run time, how many upper bits of every urgency value count as the preemption level. The remaining lower bits act only as a tie-breaker among pending requests.

The controller picks one winner among lines that are pending, enabled and not already active. It asks the core to take that winner only when no handler is running, or when the winner's preemption level is strictly more urgent than the level of the handler now running. The core answers with an acknowledge, and later with an exit when the handler finishes. A stack records each accepted line and its urgency, so that nested handlers unwind in order. Software reaches all settings through a small register port with valid and write strobes and a combinational read path.

Register map (address: meaning). Writes to 0..3 take a line mask, where bit i selects line i. 0: enable set. 1: enable clear. 2: pending set. 3: pending clear. 4: grouping, bits 2:0, read/write. 5: pending flags, read. 6: active flags, read. 7: enable flags, read. 8+i: urgency of line i, bits 3:0, read/write.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and active flag reads 0, the grouping reads 0, and take_o is low.
- R2: Writing a mask to address 2 sets and writing a mask to address 3 clears the selected pending flags. Addresses 5, 6 and 7 read back the pending, active and enable flags, with bit i for line i.
- R3: Addresses 0 and 1 set and clear enable flags. A disabled line keeps its pending flag but is never offered to the core.
- R4: The winner is the candidate with the numerically lowest 4-bit urgency. Because the preemption part sits in the upper bits, this orders candidates by preemption level and then by subpriority. Equal urgencies go to the lowest line number. The winner is shown on take_line_o.
- R5: When no handler is active, take_o is high whenever any line is pending, enabled and not active.
- R6: With grouping g, the preemption level is urgency >> (4-g). While a handler runs, take_o rises only for a winner whose preemption level is strictly lower than that of the running handler. An equal level waits.
- R7: With grouping 0, no request is taken while any handler is active. Pending requests are still ordered by urgency alone.
- R8: An acknowledge while take_o is high clears the winner's pending flag, sets its active flag and pushes it onto the nesting stack. An acknowledge while take_o is low has no effect.
- R9: An exit clears the active flag of the most recently accepted line and restores the previous handler's level for preemption. An exit with no active handler has no effect.
- R10: A high request input sets its line's pending flag on each clock while that line is not active. If the input is still high when the handler exits, the flag sets again one clock after the exit.
- R11: The grouping reads back as the 3-bit value written. Values 5 to 7 behave as 4, so all four bits count as preemption level.
- R12: When acknowledge and exit arrive in the same cycle, only the exit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NLINES | Level-sensitive request lines |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for the current address |
| take_o | output | 1 | Request to the core to take an interrupt |
| take_line_o | output | IDW | Line number of the current winner |
| ack_i | input | 1 | Core accepts the offered line |
| exit_i | input | 1 | Core leaves the innermost handler |

## Verification
The bench targets urgency ties between lines, which a faulty comparator would resolve toward the higher line number. It also checks an equal preemption level arriving during a handler; a design using non-strict comparison would nest it wrongly. Grouping values 0, 2, 3-versus-4 and 7 are exercised, because a wrong shift or a missing clamp changes which request preempts. The bench also probes stack unwinding after a two-deep nest, an exit with an empty stack, an acknowledge without an offer, a simultaneous acknowledge and exit, and a request held high across its handler, which must become pending again only after the exit. A long random run compares the offer against a reference model of the flags and the stack.

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int NLINES = 8,
  parameter int PRIO_W = 4,
  localparam int IDW = $clog2(NLINES),
  localparam int DW  = (NLINES > 8) ? NLINES : 8,
  localparam int AW  = $clog2(NLINES + 8),
  localparam int SPW = $clog2(NLINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] req_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              take_o,
  output logic [IDW-1:0]    take_line_o,
  input  logic              ack_i,
  input  logic              exit_i
);

  logic [NLINES-1:0] en_q, pend_q, act_q;
  logic [PRIO_W-1:0] prio_q [NLINES];
  logic [2:0]        grp_q;
  logic [IDW-1:0]    stk_id [NLINES];
  logic [PRIO_W-1:0] stk_p  [NLINES];
  logic [SPW-1:0]    sp_q;

  wire wr = reg_valid_i & reg_write_i;
  wire [NLINES-1:0] wmask = reg_wdata_i[NLINES-1:0];
  wire [NLINES-1:0] en_set = (wr && reg_addr_i == AW'(0)) ? wmask : '0;
  wire [NLINES-1:0] en_clr = (wr && reg_addr_i == AW'(1)) ? wmask : '0;
  wire [NLINES-1:0] p_set  = (wr && reg_addr_i == AW'(2)) ? wmask : '0;
  wire [NLINES-1:0] p_clr  = (wr && reg_addr_i == AW'(3)) ? wmask : '0;

  wire [2:0] geff  = (grp_q > 3'(PRIO_W)) ? 3'(PRIO_W) : grp_q;
  wire [2:0] shift = 3'(PRIO_W) - geff;

  wire [NLINES-1:0] cand = pend_q & en_q & ~act_q;

  logic              win_ok;
  logic [IDW-1:0]    win_id;
  logic [PRIO_W-1:0] win_p;

  always_comb begin
    win_ok = 1'b0;
    win_id = '0;
    win_p  = '1;
    for (int i = 0; i < NLINES; i++) begin
      if (cand[i] && (!win_ok || prio_q[i] < win_p)) begin
        win_ok = 1'b1;
        win_id = IDW'(i);
        win_p  = prio_q[i];
      end
    end
  end

  wire [SPW-1:0]    tix    = sp_q - SPW'(1);
  wire [IDW-1:0]    top_id = stk_id[tix[IDW-1:0]];
  wire [PRIO_W-1:0] top_p  = stk_p[tix[IDW-1:0]];
  wire preempt = (win_p >> shift) < (top_p >> shift);

  assign take_o      = win_ok && (sp_q == '0 || preempt);
  assign take_line_o = win_id;

  wire do_exit = exit_i && sp_q != '0;
  wire do_ack  = ack_i && take_o && !exit_i;
  wire [NLINES-1:0] ack_bit  = do_ack  ? (NLINES'(1) << win_id) : '0;
  wire [NLINES-1:0] exit_bit = do_exit ? (NLINES'(1) << top_id) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
      sp_q   <= '0;
      for (int i = 0; i < NLINES; i++) prio_q[i] <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= ((pend_q | p_set | (req_i & ~act_q)) & ~p_clr) & ~ack_bit;
      act_q  <= (act_q | ack_bit) & ~exit_bit;
      if (wr && reg_addr_i == AW'(4)) grp_q <= reg_wdata_i[2:0];
      for (int i = 0; i < NLINES; i++)
        if (wr && reg_addr_i == AW'(8 + i)) prio_q[i] <= reg_wdata_i[PRIO_W-1:0];
      if (do_ack)       sp_q <= sp_q + SPW'(1);
      else if (do_exit) sp_q <= sp_q - SPW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_ack) begin
      stk_id[sp_q[IDW-1:0]] <= win_id;
      stk_p[sp_q[IDW-1:0]]  <= win_p;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(4): reg_rdata_o = DW'(grp_q);
      AW'(5): reg_rdata_o = DW'(pend_q);
      AW'(6): reg_rdata_o = DW'(act_q);
      AW'(7): reg_rdata_o = DW'(en_q);
      default: ;
    endcase
    for (int i = 0; i < NLINES; i++)
      if (reg_addr_i == AW'(8 + i)) reg_rdata_o = DW'(prio_q[i]);
  end

  assert_take_cand_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (en_q[take_line_o] && pend_q[take_line_o] && !act_q[take_line_o]));

  assert_idle_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_q == '0 && (pend_q & en_q) != '0) |-> take_o);

  assert_no_preempt_g0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (geff == 3'd0 && sp_q != '0) |-> !take_o);

  assert_ack_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && take_o && !exit_i) |=>
      (act_q[$past(take_line_o)] && sp_q == $past(sp_q) + SPW'(1)));

  assert_stack_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_q) == int'(sp_q));

  assert_exit_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && sp_q != '0) |=> sp_q == $past(sp_q) - SPW'(1));

  assert_ack_exit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && exit_i && sp_q != '0) |=> sp_q == $past(sp_q) - SPW'(1));

endmodule

// File: tb/test_grp_irq_ctrl.sv
`timescale 1ns/1ps
module test_grp_irq_ctrl;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic rv = 0, rw = 0, ack = 0, ext = 0;
  logic [3:0] ra = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic take;
  logic [2:0] tline;

  grp_irq_ctrl #(.NLINES(N)) i_grp_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_valid_i(rv), .reg_write_i(rw),
    .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rd), .take_o(take),
    .take_line_o(tline), .ack_i(ack), .exit_i(ext));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [N-1:0] m_en = 0, m_pend = 0, m_act = 0;
  logic [3:0] m_prio [N];
  logic [2:0] m_grp = 0;
  int m_stk [N];
  logic [3:0] m_stkp [N];
  int m_sp = 0;

  task automatic chk(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  task automatic wreg(int a, int d);
    @(negedge clk); rv = 1; rw = 1; ra = 4'(a); wd = 8'(d);
    @(negedge clk); rv = 0; rw = 0;
  endtask

  task automatic rreg(int a, output int d);
    rv = 1; rw = 0; ra = 4'(a); #0.5; d = int'(rd); rv = 0;
  endtask

  task automatic pulse(bit a, bit e);
    @(negedge clk); ack = a; ext = e;
    @(negedge clk); ack = 0; ext = 0;
  endtask

  function automatic int exp_win();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && !m_act[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
    return w;
  endfunction

  function automatic bit exp_take();
    int w = exp_win();
    int g = (m_grp > 4) ? 4 : int'(m_grp);
    if (w < 0) return 0;
    if (m_sp == 0) return 1;
    return (m_prio[w] >> (4 - g)) < (m_stkp[m_sp-1] >> (4 - g));
  endfunction

  task automatic chk_offer(string tag, bit t, int line);
    chk({tag, " take"}, int'(take), int'(t));
    if (t) chk({tag, " line"}, int'(tline), line);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int pr [N] = '{5, 3, 3, 9, 12, 1, 8, 3};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 take", int'(take), 0);
    rreg(5, v); chk("R1 pend", v, 0);
    rreg(6, v); chk("R1 act", v, 0);
    rreg(7, v); chk("R1 en", v, 0);
    rreg(4, v); chk("R1 grp", v, 0);

    for (int i = 0; i < N; i++) wreg(8 + i, pr[i]);
    rreg(8 + 4, v); chk("R2 prio readback", v, 12);
    wreg(2, 8'h0C);
    chk("R3 disabled no take", int'(take), 0);
    rreg(5, v); chk("R2 pend set", v, 8'h0C);
    wreg(0, 8'hFF);
    rreg(7, v); chk("R3 en set", v, 8'hFF);
    chk_offer("R5 idle take", 1, 2);
    wreg(2, 8'h02);
    chk_offer("R4 tie lowest line", 1, 1);
    wreg(3, 8'h02);
    chk_offer("R2 pend clear", 1, 2);
    rreg(5, v); chk("R2 pend after clear", v, 8'h0C);
    wreg(1, 8'h04);
    chk_offer("R3 disabled skipped", 1, 3);
    rreg(5, v); chk("R3 still pending", v, 8'h0C);
    wreg(0, 8'h04);

    // nesting with grouping 2
    wreg(4, 2);
    rreg(4, v); chk("R11 grp readback", v, 2);
    wreg(3, 8'hFF);
    wreg(2, 8'h08);
    chk_offer("R5 line3", 1, 3);
    pulse(1, 0);
    rreg(6, v); chk("R8 act set", v, 8'h08);
    rreg(5, v); chk("R8 pend cleared", v, 0);
    wreg(2, 8'h40);
    chk("R6 equal level waits", int'(take), 0);
    wreg(2, 8'h02);
    chk_offer("R6 strict preempt", 1, 1);
    pulse(1, 0);
    rreg(6, v); chk("R8 nested act", v, 8'h0A);
    chk("R6 no take under nest", int'(take), 0);
    pulse(0, 1);
    rreg(6, v); chk("R9 top cleared", v, 8'h08);
    chk("R9 previous level restored", int'(take), 0);
    pulse(0, 1);
    rreg(6, v); chk("R9 all exited", v, 0);
    chk_offer("R9 empty stack take", 1, 6);
    pulse(1, 0); pulse(0, 1);
    pulse(0, 1);
    rreg(6, v); chk("R9 empty exit ignored", v, 0);
    chk("R9 empty exit take", int'(take), 0);
    pulse(1, 0);
    rreg(6, v); chk("R8 ack without take", v, 0);

    // grouping 0
    wreg(4, 0);
    wreg(2, 8'h10);
    pulse(1, 0);
    wreg(2, 8'h20);
    chk("R7 no preempt g0", int'(take), 0);
    pulse(0, 1);
    chk_offer("R7 taken after exit", 1, 5);
    pulse(1, 0); pulse(0, 1);

    // grouping 7 acts as 4
    wreg(4, 7);
    rreg(4, v); chk("R11 grp 7 readback", v, 7);
    wreg(2, 8'h08);
    pulse(1, 0);
    wreg(2, 8'h40);
    chk_offer("R11 grp7 as 4 preempt", 1, 6);
    // R12 simultaneous ack and exit
    pulse(1, 1);
    rreg(6, v); chk("R12 only exit", v, 0);
    rreg(5, v); chk("R12 pend kept", v, 8'h40);
    chk_offer("R12 offer after", 1, 6);
    pulse(1, 0); pulse(0, 1);
    wreg(4, 3);
    wreg(2, 8'h08);
    pulse(1, 0);
    wreg(2, 8'h40);
    chk("R6 grp3 equal level waits", int'(take), 0);
    wreg(3, 8'h40);
    pulse(0, 1);

    // R10 level request
    wreg(4, 0);
    @(negedge clk); req = 8'h80;
    @(negedge clk);
    chk_offer("R10 req sets pending", 1, 7);
    pulse(1, 0);
    rreg(5, v); chk("R10 no re-pend while active", v, 0);
    pulse(0, 1);
    rreg(5, v); chk("R10 not yet after exit", v, 0);
    @(negedge clk);
    rreg(5, v); chk("R10 re-pend after exit", v, 8'h80);
    req = 0;
    pulse(1, 0); pulse(0, 1);
    rreg(5, v); chk("R10 released before exit", v, 0);

    // random phase against model
    m_en = 8'hFF; m_pend = 0; m_act = 0; m_sp = 0; m_grp = 0;
    wreg(4, 0);
    for (int i = 0; i < N; i++) begin m_prio[i] = pr[i]; end
    void'($urandom(1234));
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 6);
      int ln = $urandom_range(0, N - 1);
      case (op)
        0: begin int p = $urandom_range(0, 15); wreg(8 + ln, p); m_prio[ln] = 4'(p); end
        1: begin wreg(2, 1 << ln); m_pend[ln] = 1; end
        2: begin wreg(3, 1 << ln); m_pend[ln] = 0; end
        3: if (exp_take()) begin
             int w = exp_win();
             pulse(1, 0);
             m_pend[w] = 0; m_act[w] = 1; m_stk[m_sp] = w; m_stkp[m_sp] = m_prio[w]; m_sp++;
           end
        4: begin
             pulse(0, 1);
             if (m_sp > 0) begin m_sp--; m_act[m_stk[m_sp]] = 0; end
           end
        5: begin int g = $urandom_range(0, 7); wreg(4, g); m_grp = 3'(g); end
        default: begin wreg(1, 1 << ln); m_en[ln] = 0; wreg(0, 1 << ((ln + 3) % N)); m_en[(ln + 3) % N] = 1; end
      endcase
      chk_offer("R4 R6 random", exp_take(), exp_win());
    end
    rreg(6, v); chk("R8 random act", v, int'(m_act));
    rreg(5, v); chk("R2 random pend", v, int'(m_pend));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule